// File: doc/BRIEF.md
# STM-0 Transmit Overhead Alarm Inserter

This block sits in the outbound path of an STM-0 transmitter and rewrites section overhead bytes of a byte-wide frame stream under the control of one 8-bit register. It tracks the position of each byte in the 9-row frame from a start-of-frame strobe. It replaces unassigned overhead bytes with a programmable fill, fills the M0/M1 byte from one of three sources, writes the remote-defect code into K2, and can corrupt a single A1 or B2 byte on demand. It can force the multiplex-section alarm pattern or an all-zero loss-of-signal line, and it applies the frame-synchronous scrambler.

Forced conditions follow a fixed priority. Loss of signal beats the multiplex-section alarm, and that beats remote defect. Each output byte leaves one clock after the input byte that produced it. The frame width and the set of unassigned overhead positions are parameters.

Top module: `stm0_oh_inserter`

## Requirements
- R1: `out_valid` and `out_sof` equal `in_valid` and `in_valid & in_sof` one clock earlier. The processed byte appears on `out_byte` one clock after it is accepted. `in_sof` marks row 0, column 0 (rows and columns count from 0). The position advances by one column for each accepted byte and wraps after column COLS-1 (default 90) and after row 8.
- R2: With control bit 3 (force loss of signal) set, every output byte is 0x00, whatever the other bits say.
- R3: With control bit 4 (force line alarm) set and bit 3 clear, every byte in rows 3 to 8 is replaced by 0xFF before scrambling. Rows 0 to 2 keep their other processing.
- R4: With control bit 5 (force remote defect) set, the K2 byte at row 4, column 2 has its bits 2:0 replaced by 110, and bits 7:3 pass from the input. This has no effect while bit 4 or bit 3 is set.
- R5: The unassigned overhead bytes (default row 1 columns 1 and 2, and row 8 column 2) become 0x00 when control bit 6 is 0 and 0xFF when it is 1.
- R6: The M0/M1 byte at row 8, column 1 is chosen by the code {`m0m1_sel_hi`, control bit 7}. Code 01 selects `m0m1_reg_byte`, 10 selects `ser_oh_byte`, and 00 and 11 both select `rx_b2_errcnt`.
- R7: After reset the control register is 0x00, no error insertion is pending, and `out_valid` is 0.
- R8: Writing control bit 0 as 1 inverts the next A1 byte (row 0, column 0) exactly once. Later frames pass A1 unchanged until another such write.
- R9: Writing control bit 1 as 1 inverts the next B2 byte (row 4, column 0) exactly once.
- R10: With control bit 2 set, every byte except columns 0 to 2 of row 0 is XORed with a keystream. The generator is 7 bits wide, takes the output bit from bit 6, feeds back bit6^bit5 into bit 0 on a left shift, and produces 8 bits per byte, MSB first. It advances on every accepted byte and is loaded with all ones after row 0, column 2. Processing order is: overhead overlays, line alarm, scrambling, then loss of signal.
- R11: With no overlay, alarm or scrambling affecting a position, the byte passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| m0m1_sel_hi | input | 1 | Upper bit of the M0/M1 source code |
| m0m1_reg_byte | input | 8 | Programmed M0/M1 value |
| ser_oh_byte | input | 8 | M0/M1 byte taken from the serial overhead port |
| rx_b2_errcnt | input | 8 | Receive-side B2 error count |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is row 0, column 0 |
| in_byte | input | 8 | Input frame byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output byte is row 0, column 0 |
| out_byte | output | 8 | Processed frame byte |

## Verification
The hardest states to reach are the ones where several forced conditions or one-shot insertions meet at the same byte. Examples are a pending B2 corruption that lands under the line alarm, a remote-defect request hidden by loss of signal, and the scrambler restarting inside a frame that a premature start-of-frame has cut short. Directed frames set each of these combinations once, with control writes placed in idle gaps between frames. Random frames then add irregular valid gaps, truncated frames and random control words, and every output byte is compared with a bench model of the frame.

// File: rtl/stm0_oh_pkg.sv
package stm0_oh_pkg;

   localparam int BYTE_W = 8;

   // control word bit positions
   localparam int CB_A1_ERR  = 0;
   localparam int CB_B2_ERR  = 1;

   // bits 7:2 of the control word, MSB first
   typedef struct packed {
      logic m0m1_sel_lo;
      logic undef_ones;
      logic force_rdi;
      logic force_ais;
      logic force_los;
      logic scr_en;
   } ctrl_t;

   typedef enum logic [1:0] {
      SRC_ERRCNT_A = 2'b00,
      SRC_PROG     = 2'b01,
      SRC_SERIAL   = 2'b10,
      SRC_ERRCNT_B = 2'b11
   } m0m1_src_e;

   // overhead byte positions (row, column from 0)
   localparam int POS_A1_R = 0, POS_A1_C = 0;
   localparam int POS_B2_R = 4, POS_B2_C = 0;
   localparam int POS_K2_R = 4, POS_K2_C = 2;
   localparam int POS_MM_R = 8, POS_MM_C = 1;
   localparam int RSOH_ROWS = 3;

   // one byte of keystream plus the following generator state
   function automatic logic [14:0] scr_byte(input logic [6:0] s);
      logic [6:0] t;
      logic [7:0] k;
      t = s;
      for (int i = 7; i >= 0; i--) begin
         k[i] = t[6];
         t    = {t[5:0], t[6] ^ t[5]};
      end
      return {k, t};
   endfunction

endpackage

// File: rtl/stm0_frame_pos.sv
module stm0_frame_pos #(
   parameter int ROWS  = 9,
   parameter int COLS  = 90,
   parameter int ROW_W = 4,
   parameter int COL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   output logic [ROW_W-1:0] cur_row,
   output logic [COL_W-1:0] cur_col
);

   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;

   always_comb begin
      cur_row = in_sof ? '0 : row_q;
      cur_col = in_sof ? '0 : col_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
      end else if (in_valid) begin
         if (cur_col == COL_LAST) begin
            col_q <= '0;
            row_q <= (cur_row == ROW_LAST) ? '0 : cur_row + 1'b1;
         end else begin
            col_q <= cur_col + 1'b1;
         end
      end
   end

   // R1
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_q <= COL_LAST) && (row_q <= ROW_LAST));

endmodule

// File: rtl/stm0_ctrl_reg.sv
module stm0_ctrl_reg
   import stm0_oh_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [7:0]  wdata,
   input  logic        a1_take,
   input  logic        b2_take,
   output ctrl_t       ctrl,
   output logic        a1_pend,
   output logic        b2_pend
);

   logic a1_arm, b2_arm;

   assign a1_arm = wr && wdata[CB_A1_ERR];
   assign b2_arm = wr && wdata[CB_B2_ERR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl    <= '0;
         a1_pend <= 1'b0;
         b2_pend <= 1'b0;
      end else begin
         if (wr) ctrl <= ctrl_t'(wdata[7:2]);
         if (a1_arm)       a1_pend <= 1'b1;
         else if (a1_take) a1_pend <= 1'b0;
         if (b2_arm)       b2_pend <= 1'b1;
         else if (b2_take) b2_pend <= 1'b0;
      end
   end

   // R8
   a1_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a1_take && !a1_arm) |=> !a1_pend);

   // R9
   b2_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b2_take && !b2_arm) |=> !b2_pend);

endmodule

// File: rtl/stm0_scrambler.sv
module stm0_scrambler
   import stm0_oh_pkg::*;
#(
   parameter bit HAS_SCR = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        adv,
   input  logic        reload,
   output logic [7:0]  keystream
);

   generate
      if (HAS_SCR) begin : g_lfsr
         logic [6:0]  st_q;
         logic [14:0] step;

         assign step      = scr_byte(st_q);
         assign keystream = step[14:7];

         always_ff @(posedge clk) begin
            if (!rst_n)      st_q <= 7'h7F;
            else if (reload) st_q <= 7'h7F;
            else if (adv)    st_q <= step[6:0];
         end

         // R10
         scr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            reload |=> (st_q == 7'h7F));
      end else begin : g_none
         assign keystream = '0;
      end
   endgenerate

endmodule

// File: rtl/stm0_oh_inserter.sv
module stm0_oh_inserter
   import stm0_oh_pkg::*;
#(
   parameter int          ROWS       = 9,
   parameter int          COLS       = 90,
   parameter int          OH_COLS    = 3,
   parameter bit          HAS_SCR    = 1'b1,
   parameter logic [63:0] UNDEF_MASK = 64'h0000_0000_0400_0030
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_wr,
   input  logic [7:0] ctrl_wdata,
   input  logic       m0m1_sel_hi,
   input  logic [7:0] m0m1_reg_byte,
   input  logic [7:0] ser_oh_byte,
   input  logic [7:0] rx_b2_errcnt,
   input  logic       in_valid,
   input  logic       in_sof,
   input  logic [7:0] in_byte,
   output logic       out_valid,
   output logic       out_sof,
   output logic [7:0] out_byte
);

   localparam int ROW_W = $clog2(ROWS + 1);
   localparam int COL_W = $clog2(COLS + 1);
   localparam int OH_POS = ROWS * OH_COLS;

   localparam logic [ROW_W-1:0] R_A1   = ROW_W'(POS_A1_R);
   localparam logic [ROW_W-1:0] R_B2   = ROW_W'(POS_B2_R);
   localparam logic [ROW_W-1:0] R_K2   = ROW_W'(POS_K2_R);
   localparam logic [ROW_W-1:0] R_MM   = ROW_W'(POS_MM_R);
   localparam logic [ROW_W-1:0] R_MSOH = ROW_W'(RSOH_ROWS);
   localparam logic [COL_W-1:0] C_A1   = COL_W'(POS_A1_C);
   localparam logic [COL_W-1:0] C_B2   = COL_W'(POS_B2_C);
   localparam logic [COL_W-1:0] C_K2   = COL_W'(POS_K2_C);
   localparam logic [COL_W-1:0] C_MM   = COL_W'(POS_MM_C);
   localparam logic [COL_W-1:0] C_OH   = COL_W'(OH_COLS);
   localparam logic [COL_W-1:0] C_OHL  = COL_W'(OH_COLS - 1);

   // elaboration-time parameter checks
   generate
      if (ROWS != 9) begin : g_bad_rows
         $error("stm0_oh_inserter: ROWS must be 9");
      end
      if (OH_COLS < 3 || COLS <= OH_COLS) begin : g_bad_cols
         $error("stm0_oh_inserter: need 3 <= OH_COLS < COLS");
      end
      if (OH_POS > 64) begin : g_bad_mask
         $error("stm0_oh_inserter: overhead mask wider than 64");
      end
   endgenerate

   logic [ROW_W-1:0] cur_row;
   logic [COL_W-1:0] cur_col;
   ctrl_t            ctrl;
   logic             a1_pend, b2_pend;
   logic             at_a1, at_b2, at_k2, at_mm, in_soh, undef_hit;
   logic             scr_skip;
   logic [7:0]       ks;
   logic [7:0]       oh_idx;
   logic [7:0]       mm_byte;
   logic [7:0]       ovl_byte, ais_byte, scr_out, fin_byte;
   m0m1_src_e        mm_src;

   stm0_frame_pos #(
      .ROWS (ROWS), .COLS (COLS), .ROW_W (ROW_W), .COL_W (COL_W)
   ) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sof   (in_sof),
      .cur_row  (cur_row),
      .cur_col  (cur_col)
   );

   stm0_ctrl_reg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (ctrl_wr),
      .wdata   (ctrl_wdata),
      .a1_take (in_valid && at_a1),
      .b2_take (in_valid && at_b2),
      .ctrl    (ctrl),
      .a1_pend (a1_pend),
      .b2_pend (b2_pend)
   );

   stm0_scrambler #(.HAS_SCR (HAS_SCR)) u_scr (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (in_valid),
      .reload    (in_valid && cur_row == R_A1 && cur_col == C_OHL),
      .keystream (ks)
   );

   // position decode
   always_comb begin
      at_a1     = (cur_row == R_A1) && (cur_col == C_A1);
      at_b2     = (cur_row == R_B2) && (cur_col == C_B2);
      at_k2     = (cur_row == R_K2) && (cur_col == C_K2);
      at_mm     = (cur_row == R_MM) && (cur_col == C_MM);
      in_soh    = cur_col < C_OH;
      oh_idx    = 8'(cur_row) * 8'(OH_COLS) + 8'(cur_col);
      undef_hit = in_soh && UNDEF_MASK[oh_idx[5:0]];
      scr_skip  = (cur_row == R_A1) && in_soh;
   end

   // M0/M1 source selection
   always_comb begin
      mm_src = m0m1_src_e'({m0m1_sel_hi, ctrl.m0m1_sel_lo});
      unique case (mm_src)
         SRC_PROG:   mm_byte = m0m1_reg_byte;
         SRC_SERIAL: mm_byte = ser_oh_byte;
         default:    mm_byte = rx_b2_errcnt;
      endcase
   end

   // overhead overlays, then alarms, scrambling and line blanking
   always_comb begin
      ovl_byte = in_byte;
      if (undef_hit)
         ovl_byte = ctrl.undef_ones ? 8'hFF : 8'h00;
      if (at_mm)
         ovl_byte = mm_byte;
      if (at_k2 && ctrl.force_rdi)
         ovl_byte = {in_byte[7:3], 3'b110};
      if ((at_b2 && b2_pend) || (at_a1 && a1_pend))
         ovl_byte = ~in_byte;

      ais_byte = (ctrl.force_ais && cur_row >= R_MSOH) ? 8'hFF : ovl_byte;
      scr_out  = (ctrl.scr_en && !scr_skip) ? (ais_byte ^ ks) : ais_byte;
      fin_byte = ctrl.force_los ? 8'h00 : scr_out;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_byte  <= '0;
      end else begin
         out_valid <= in_valid;
         out_sof   <= in_valid && in_sof;
         if (in_valid) out_byte <= fin_byte;
      end
   end

   // R1
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2
   los_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ctrl.force_los) |=> (out_byte == 8'h00));

   // R3
   ais_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ctrl.force_ais && !ctrl.force_los && !ctrl.scr_en &&
       cur_row >= R_MSOH) |=> (out_byte == 8'hFF));

   // R4
   rdi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && at_k2 && ctrl.force_rdi && !ctrl.force_ais &&
       !ctrl.force_los && !ctrl.scr_en) |=> (out_byte[2:0] == 3'b110));

   // R6
   mm_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && at_mm && mm_src == SRC_PROG && !ctrl.force_ais &&
       !ctrl.force_los && !ctrl.scr_en) |=> (out_byte == $past(m0m1_reg_byte)));

endmodule

// File: tb/stm0_oh_inserter_tb.sv
module stm0_oh_inserter_tb;

   localparam int COLS = 90;
   localparam int ROWS = 9;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ctrl_wr;
   logic [7:0] ctrl_wdata;
   logic       m0m1_sel_hi;
   logic [7:0] m0m1_reg_byte, ser_oh_byte, rx_b2_errcnt;
   logic       in_valid, in_sof;
   logic [7:0] in_byte;
   logic       out_valid, out_sof;
   logic [7:0] out_byte;

   always #2.5 clk = ~clk;

   stm0_oh_inserter u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctrl_wr       (ctrl_wr),
      .ctrl_wdata    (ctrl_wdata),
      .m0m1_sel_hi   (m0m1_sel_hi),
      .m0m1_reg_byte (m0m1_reg_byte),
      .ser_oh_byte   (ser_oh_byte),
      .rx_b2_errcnt  (rx_b2_errcnt),
      .in_valid      (in_valid),
      .in_sof        (in_sof),
      .in_byte       (in_byte),
      .out_valid     (out_valid),
      .out_sof       (out_sof),
      .out_byte      (out_byte)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // bench model state
   logic [7:0] m_ctrl;
   logic       m_pa1, m_pb2;
   logic [6:0] m_st;
   int         m_row, m_col;
   logic       exp_v, exp_sof;
   logic [7:0] exp_b;
   string      exp_tag;

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   function automatic bit is_undef(input int r, input int c);
      return (r == 1 && (c == 1 || c == 2)) || (r == 8 && c == 2);
   endfunction

   // keystream per R10: out bit 6, left shift, feedback bit6^bit5
   function automatic logic [7:0] ks_of(input logic [6:0] s);
      logic [7:0] k;
      for (int i = 7; i >= 0; i--) begin
         k[i] = s[6];
         s    = {s[5:0], s[6] ^ s[5]};
      end
      return k;
   endfunction

   function automatic logic [6:0] st_next(input logic [6:0] s);
      for (int i = 0; i < 8; i++) s = {s[5:0], s[6] ^ s[5]};
      return s;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // one clock: compare previous result, drive new inputs, predict
   task automatic step(input logic v, input logic s, input logic [7:0] b,
                       input logic wr, input logic [7:0] wd);
      int r, c;
      logic [7:0] e;
      logic [1:0] sel;
      check("R1 valid", {7'd0, out_valid}, {7'd0, exp_v});
      if (exp_v) begin
         check("R1 sof", {7'd0, out_sof}, {7'd0, exp_sof});
         check(exp_tag, out_byte, exp_b);
      end
      m0m1_reg_byte = 8'($urandom);
      ser_oh_byte   = 8'($urandom);
      rx_b2_errcnt  = 8'($urandom);
      in_valid = v; in_sof = s; in_byte = b;
      ctrl_wr = wr; ctrl_wdata = wd;
      exp_v = v; exp_sof = v && s;
      if (v) begin
         r = s ? 0 : m_row;
         c = s ? 0 : m_col;
         e = b; exp_tag = "R11 pass";
         if (is_undef(r, c)) begin
            e = m_ctrl[6] ? 8'hFF : 8'h00; exp_tag = "R5 fill";
         end
         if (r == 8 && c == 1) begin
            sel = {m0m1_sel_hi, m_ctrl[7]};
            e = (sel == 2'b01) ? m0m1_reg_byte : (sel == 2'b10) ? ser_oh_byte : rx_b2_errcnt;
            exp_tag = "R6 m0m1";
         end
         if (r == 4 && c == 2 && m_ctrl[5]) begin
            e = {b[7:3], 3'b110}; exp_tag = "R4 k2";
         end
         if (r == 4 && c == 0) begin
            if (m_pb2) begin e = ~b; exp_tag = "R9 b2err"; end
            m_pb2 = 0;
         end
         if (r == 0 && c == 0) begin
            if (m_pa1) begin e = ~b; exp_tag = "R8 a1err"; end
            m_pa1 = 0;
         end
         if (m_ctrl[4] && r >= 3) begin e = 8'hFF; exp_tag = "R3 ais"; end
         if (m_ctrl[2] && !(r == 0 && c < 3)) begin
            e = e ^ ks_of(m_st); exp_tag = {exp_tag, " R10 scr"};
         end
         m_st = (r == 0 && c == 2) ? 7'h7F : st_next(m_st);
         if (m_ctrl[3]) begin e = 8'h00; exp_tag = "R2 los"; end
         exp_b = e;
         c++;
         if (c == COLS) begin c = 0; r = (r == ROWS - 1) ? 0 : r + 1; end
         m_row = r; m_col = c;
      end
      if (wr) begin
         m_ctrl = wd;
         if (wd[0]) m_pa1 = 1;
         if (wd[1]) m_pb2 = 1;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send_frame(input int len);
      for (int i = 0; i < len; i++) begin
         while ($urandom % 10 == 0) step(0, 0, 8'($urandom), 0, 8'h00);
         step(1, i == 0, 8'($urandom), 0, 8'h00);
      end
   endtask

   task automatic write_ctrl(input logic hi, input logic [7:0] wd);
      m0m1_sel_hi = hi;
      step(0, 0, 8'h00, 1, wd);
      step(0, 0, 8'h00, 0, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      logic [7:0] wd;
      void'($urandom(32'd20251));
      rst_n = 0; ctrl_wr = 0; ctrl_wdata = 0; m0m1_sel_hi = 0;
      m0m1_reg_byte = 0; ser_oh_byte = 0; rx_b2_errcnt = 0;
      in_valid = 0; in_sof = 0; in_byte = 0;
      m_ctrl = 0; m_pa1 = 0; m_pb2 = 0; m_st = 7'h7F; m_row = 0; m_col = 0;
      exp_v = 0; exp_sof = 0; exp_b = 0; exp_tag = "";
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R7: reset state, outputs idle
      check("R7 reset valid", {7'd0, out_valid}, 8'h00);
      check("R7 reset byte", out_byte, 8'h00);
      // R7/R11: defaults give pass-through, no pending insertion
      send_frame(ROWS * COLS);
      write_ctrl(0, 8'h38);  // R2 los over ais and rdi
      send_frame(ROWS * COLS);
      write_ctrl(0, 8'h30);  // R3 ais hides R4
      send_frame(ROWS * COLS);
      write_ctrl(0, 8'h20);  // R4 rdi alone
      send_frame(ROWS * COLS);
      write_ctrl(0, 8'h40);  // R5 ones fill, R6 code 00
      send_frame(ROWS * COLS);
      write_ctrl(0, 8'h80);  // R6 code 01
      send_frame(ROWS * COLS);
      write_ctrl(1, 8'h00);  // R6 code 10
      send_frame(ROWS * COLS);
      write_ctrl(1, 8'h80);  // R6 code 11
      send_frame(ROWS * COLS);
      write_ctrl(0, 8'h03);  // R8 R9 one-shot
      send_frame(ROWS * COLS);
      write_ctrl(0, 8'h00);  // R8 R9 not repeated
      send_frame(ROWS * COLS);
      write_ctrl(0, 8'h04);  // R10 scrambling
      send_frame(ROWS * COLS);
      write_ctrl(0, 8'h16);  // R3 with R9 pending and R10
      send_frame(ROWS * COLS);
      write_ctrl(0, 8'h0B);  // R2 with pending R8 R9 consumed
      send_frame(ROWS * COLS);
      write_ctrl(0, 8'h00);
      send_frame(ROWS * COLS);
      for (int f = 0; f < 8; f++) begin
         wd = 8'($urandom);
         if ($urandom % 4 != 0) wd[3] = 1'b0;
         write_ctrl(1'($urandom), wd);
         // R1: some frames cut short by an early start of frame
         send_frame(($urandom % 4 == 0) ? 100 + int'($urandom % 500) : ROWS * COLS);
      end
      step(0, 0, 8'h00, 0, 8'h00);
      finish_run();
   end

endmodule